// File: doc/BRIEF.md
# UART FIFO Trigger-Level Interrupt Generator

This block produces the interrupt request for one UART channel from the fill state of its transmit and receive queues. It holds both queues itself, 128 bytes each by default. The host side pushes transmit bytes and pops receive bytes. The serial side pops transmit bytes and pushes receive bytes. A busy flag from the external serializer shows whether the transmit shift register still holds a character.

There are two operating styles. With queueing off, each side keeps a single holding byte that a new write replaces. With queueing on, each side is a full first-in first-out queue that has its own programmable trigger level. The transmit condition asks for more data when the transmit side runs low. The receive condition asks for service when the receive side fills up. A select input makes the transmit condition wait until the shift register has also drained. Each condition has its own enable, and the two are ORed onto one registered, active-high request line. A DMA-mode input is accepted but does not change the request.

Top module: `uart_trig_irq`

## Requirements
- R1: With `fifo_en`=1, each side stores up to DEPTH (128) bytes and returns them in push order. `*_count` gives the number held. A push and a pop in the same cycle are both carried out, even when the side is full.
- R2: With `fifo_en`=1, a push to a full side is discarded and sets that side's `*_ovf` flag. The flag stays set until reset.
- R3: A pop from an empty side leaves `*_count` at 0 and keeps `*_rdata` at its previous value.
- R4: With `fifo_en`=0, each side holds at most one byte. A push always replaces the held byte, the count becomes 1, and `*_ovf` is never set.
- R5: Any change of `fifo_en` empties both sides on the clock edge where the new value is first seen. Pushes and pops in that cycle are ignored.
- R6: With `fifo_en`=0, the transmit condition is true when the transmit count is 0. If `txe_sel`=1, `shift_busy` must also be 0.
- R7: With `fifo_en`=1, the transmit condition is true when 0 < count <= `tx_trig`. It is also true when the count is 0, under the same `txe_sel`/`shift_busy` rule as R6.
- R8: With `fifo_en`=0, the receive condition is true when count is 1. With `fifo_en`=1, it is true when count >= `rx_trig` and count > 0.
- R9: `irq` is registered. After each edge it equals (`tx_ie` AND transmit condition) OR (`rx_ie` AND receive condition), evaluated from the counts held before that edge and from the inputs at that edge. `dma_mode` has no effect.
- R10: While `rst` is high (synchronous), both counts, both overflow flags, both read-data outputs and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = queue mode, 0 = single holding byte |
| dma_mode | input | 1 | DMA signalling mode, no effect on the request |
| txe_sel | input | 1 | 1 = empty transmit also needs an idle shift register |
| tx_trig | input | CNT_W (8) | Transmit trigger level |
| rx_trig | input | CNT_W (8) | Receive trigger level |
| tx_ie | input | 1 | Transmit condition enable |
| rx_ie | input | 1 | Receive condition enable |
| shift_busy | input | 1 | Serializer shift register holds a character |
| tx_push | input | 1 | Host writes a transmit byte |
| tx_wdata | input | DATA_W (8) | Transmit write data |
| tx_pop | input | 1 | Serializer takes a transmit byte |
| tx_rdata | output | DATA_W (8) | Last byte taken from the transmit side |
| tx_count | output | CNT_W (8) | Transmit fill count |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_push | input | 1 | Deserializer delivers a received byte |
| rx_wdata | input | DATA_W (8) | Receive write data |
| rx_pop | input | 1 | Host reads a received byte |
| rx_rdata | output | DATA_W (8) | Last byte taken from the receive side |
| rx_count | output | CNT_W (8) | Receive fill count |
| rx_ovf | output | 1 | Sticky receive overflow |
| irq | output | 1 | Registered active-high interrupt request |

## Verification
The assertions check on every cycle that counts stay within the bound of the current mode, that overflow is sticky, that an empty pop changes nothing, that a mode change empties the queues, that masked or empty conditions keep `irq` low, and that an idle empty transmitter raises it. Only the bench scenarios can show that data comes out in order, that the held byte is replaced in single-byte mode, and that `irq` switches exactly at the trigger boundaries (count equal to trigger, one above, one below) with `txe_sel` and `shift_busy` in each combination. The bench checks these against a reference model on random traffic and on directed cases.

// File: rtl/uart_trig_irq_pkg.sv
package uart_trig_irq_pkg;

    localparam int DEF_DATA_W = 8;
    localparam int DEF_DEPTH  = 128;

    typedef enum logic {
        MODE_BYTE  = 1'b0,
        MODE_QUEUE = 1'b1
    } fifo_mode_e;

    typedef struct packed {
        logic tx;
        logic rx;
    } irq_src_t;

    // Empty transmit side counts as drained only when the shift
    // register is idle, if the select asks for it.
    function automatic logic tx_condition(input fifo_mode_e mode, input logic sel,
                                          input logic busy, input int unsigned cnt,
                                          input int unsigned trig);
        logic drained;
        drained = (cnt == 0) && (!sel || !busy);
        if (mode == MODE_BYTE)
            return drained;
        return drained || ((cnt != 0) && (cnt <= trig));
    endfunction

    function automatic logic rx_condition(input fifo_mode_e mode, input int unsigned cnt,
                                          input int unsigned trig);
        if (mode == MODE_BYTE)
            return cnt != 0;
        return (cnt != 0) && (cnt >= trig);
    endfunction

endpackage

// File: rtl/trig_fifo.sv
module trig_fifo
    import uart_trig_irq_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int DEPTH  = DEF_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  fifo_mode_e        mode,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              ovf
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              queued;
    logic              full;
    logic              do_pop;
    logic              do_push;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        queued  = (mode == MODE_QUEUE);
        full    = queued && (count == CNT_W'(DEPTH));
        do_pop  = pop && (count != '0);
        do_push = push && (!full || do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst && !flush && do_push)
            mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
            rdata  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push && !do_push)
                ovf <= 1'b1;
            if (do_pop)
                rdata <= mem[rd_ptr];
            if (queued) begin
                if (do_push)
                    wr_ptr <= ptr_inc(wr_ptr);
                if (do_pop)
                    rd_ptr <= ptr_inc(rd_ptr);
                case ({do_push, do_pop})
                    2'b10:   count <= count + 1'b1;
                    2'b01:   count <= count - 1'b1;
                    default: count <= count;
                endcase
            end else begin
                if (do_push)
                    count <= CNT_W'(1);
                else if (do_pop)
                    count <= '0;
            end
        end
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    assert_ovf_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    assert_full_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (queued && !flush && push && !pop && count == CNT_W'(DEPTH))
        |=> (count == CNT_W'(DEPTH) && ovf));

    assert_empty_pop_R3: assert property (@(posedge clk) disable iff (rst)
        (!flush && pop && !push && count == '0) |=> (count == '0 && $stable(rdata)));

    assert_byte_depth_R4: assert property (@(posedge clk) disable iff (rst)
        (!queued && !flush) |=> (count <= CNT_W'(1)));

    assert_flush_empties_R5: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

endmodule

// File: rtl/irq_eval.sv
module irq_eval
    import uart_trig_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  fifo_mode_e       mode,
    input  logic             dma_mode,
    input  logic             txe_sel,
    input  logic             shift_busy,
    input  logic             tx_ie,
    input  logic             rx_ie,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] tx_trig,
    input  logic [CNT_W-1:0] rx_trig,
    output logic             irq
);

    irq_src_t src;

    always_comb begin
        src.tx = tx_ie && tx_condition(mode, txe_sel, shift_busy,
                                       32'(tx_cnt), 32'(tx_trig));
        src.rx = rx_ie && rx_condition(mode, 32'(rx_cnt), 32'(rx_trig));
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else
            irq <= src.tx || src.rx;
    end

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!tx_ie && !rx_ie) |=> !irq);

    assert_rx_empty_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!tx_ie && rx_cnt == '0) |=> !irq);

    assert_tx_idle_fires_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_ie && tx_cnt == '0 && !shift_busy) |=> irq);

    assert_dma_neutral_R9: assert property (@(posedge clk) disable iff (rst)
        (dma_mode && tx_ie && tx_cnt == '0 && !shift_busy) |=> irq);

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> !irq);

endmodule

// File: rtl/uart_trig_irq.sv
module uart_trig_irq
    import uart_trig_irq_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int DEPTH  = DEF_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic              dma_mode,
    input  logic              txe_sel,
    input  logic [CNT_W-1:0]  tx_trig,
    input  logic [CNT_W-1:0]  rx_trig,
    input  logic              tx_ie,
    input  logic              rx_ie,
    input  logic              shift_busy,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    output logic [CNT_W-1:0]  tx_count,
    output logic              tx_ovf,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_ovf,
    output logic              irq
);

    logic       en_q;
    logic       flush;
    fifo_mode_e mode;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else
            en_q <= fifo_en;
    end

    always_comb begin
        flush = (fifo_en != en_q);
        mode  = fifo_en ? MODE_QUEUE : MODE_BYTE;
    end

    trig_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst), .flush(flush), .mode(mode),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
        .rdata(tx_rdata), .count(tx_count), .ovf(tx_ovf)
    );

    trig_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst), .flush(flush), .mode(mode),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
        .rdata(rx_rdata), .count(rx_count), .ovf(rx_ovf)
    );

    irq_eval #(.CNT_W(CNT_W)) u_eval (
        .clk(clk), .rst(rst), .mode(mode), .dma_mode(dma_mode),
        .txe_sel(txe_sel), .shift_busy(shift_busy),
        .tx_ie(tx_ie), .rx_ie(rx_ie),
        .tx_cnt(tx_count), .rx_cnt(rx_count),
        .tx_trig(tx_trig), .rx_trig(rx_trig),
        .irq(irq)
    );

endmodule

// File: tb/uart_trig_irq_tb.sv
`timescale 1ns/1ps
module uart_trig_irq_tb;

    localparam int DW    = 8;
    localparam int DEPTH = 128;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fifo_en = 0, dma_mode = 0, txe_sel = 0, tx_ie = 0, rx_ie = 0, shift_busy = 0;
    logic [CW-1:0] tx_trig = 0, rx_trig = 0;
    logic          tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
    logic [DW-1:0] tx_wdata = 0, rx_wdata = 0;
    logic [DW-1:0] tx_rdata, rx_rdata;
    logic [CW-1:0] tx_count, rx_count;
    logic          tx_ovf, rx_ovf, irq;

    int checks = 0;
    int errors = 0;

    // reference model: index 0 = transmit, 1 = receive
    logic [DW-1:0] mq [2][DEPTH];
    int            mh [2];
    int            mc [2];
    logic [DW-1:0] mrd [2];
    bit            movf [2];
    bit            men_q;
    bit            exp_irq;

    always #5 clk = ~clk;

    uart_trig_irq #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_mode(dma_mode),
        .txe_sel(txe_sel), .tx_trig(tx_trig), .rx_trig(rx_trig),
        .tx_ie(tx_ie), .rx_ie(rx_ie), .shift_busy(shift_busy),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .tx_rdata(tx_rdata), .tx_count(tx_count), .tx_ovf(tx_ovf),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
        .rx_rdata(rx_rdata), .rx_count(rx_count), .rx_ovf(rx_ovf),
        .irq(irq)
    );

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic bit want_tx(input bit en, input bit sel, input bit busy, input int c, input int t);
        if (c == 0) return sel ? !busy : 1'b1;
        return en && (c <= t);
    endfunction

    function automatic bit want_rx(input bit en, input int c, input int t);
        if (c == 0) return 1'b0;
        return en ? (c >= t) : 1'b1;
    endfunction

    function automatic void model_side(input int s, input bit push, input logic [DW-1:0] w,
                                       input bit pop, input bit en, input bit flush);
        bit popv, full;
        if (flush) begin
            mh[s] = 0;
            mc[s] = 0;
            return;
        end
        popv = pop && (mc[s] > 0);
        full = (mc[s] == DEPTH);
        if (en) begin
            if (popv) begin
                mrd[s] = mq[s][mh[s]];
                mh[s]  = (mh[s] + 1) % DEPTH;
                mc[s]--;
            end
            if (push) begin
                if (!full || popv) begin
                    mq[s][(mh[s] + mc[s]) % DEPTH] = w;
                    mc[s]++;
                end else begin
                    movf[s] = 1'b1;
                end
            end
        end else begin
            if (popv) begin
                mrd[s] = mq[s][mh[s]];
                mc[s]  = 0;
            end
            if (push) begin
                mh[s]    = 0;
                mq[s][0] = w;
                mc[s]    = 1;
            end
        end
    endfunction

    // Called at a negedge; returns at the next negedge with all outputs checked.
    task automatic cyc(input bit tp, input logic [DW-1:0] tw, input bit to,
                       input bit rp, input logic [DW-1:0] rw, input bit ro);
        bit flush;
        tx_push = tp; tx_wdata = tw; tx_pop = to;
        rx_push = rp; rx_wdata = rw; rx_pop = ro;
        exp_irq = (tx_ie && want_tx(fifo_en, txe_sel, shift_busy, mc[0], int'(tx_trig)))
               || (rx_ie && want_rx(fifo_en, mc[1], int'(rx_trig)));
        flush = (fifo_en != men_q);
        men_q = fifo_en;
        model_side(0, tp, tw, to, fifo_en, flush);
        model_side(1, rp, rw, ro, fifo_en, flush);
        @(posedge clk);
        @(negedge clk);
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        chk(int'(tx_count), mc[0], "R1 tx_count");
        chk(int'(rx_count), mc[1], "R1 rx_count");
        chk(int'(tx_rdata), int'(mrd[0]), "R1 tx_rdata");
        chk(int'(rx_rdata), int'(mrd[1]), "R1 rx_rdata");
        chk(int'(tx_ovf), int'(movf[0]), "R2 tx_ovf");
        chk(int'(rx_ovf), int'(movf[1]), "R2 rx_ovf");
        chk(int'(irq), int'(exp_irq), "R9 irq");
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_1234);
        for (int s = 0; s < 2; s++) begin
            mh[s] = 0; mc[s] = 0; mrd[s] = '0; movf[s] = 1'b0;
        end
        men_q = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(int'(tx_count), 0, "R10 tx_count in reset");
        chk(int'(rx_count), 0, "R10 rx_count in reset");
        chk(int'(tx_ovf) + int'(rx_ovf), 0, "R10 ovf in reset");
        chk(int'(tx_rdata) + int'(rx_rdata), 0, "R10 rdata in reset");
        chk(int'(irq), 0, "R10 irq in reset");
        rst = 1'b0;

        // Single-byte mode
        rx_ie = 1;
        cyc(0, 0, 0, 1, 8'hA1, 0);
        cyc(0, 0, 0, 1, 8'hB2, 0);
        chk(int'(rx_count), 1, "R4 overwrite keeps count 1");
        chk(int'(rx_ovf), 0, "R4 no overflow in byte mode");
        chk(int'(irq), 1, "R8 byte held raises receive");
        cyc(0, 0, 0, 0, 0, 1);
        chk(int'(rx_rdata), 8'hB2, "R4 newest byte returned");
        cyc(0, 0, 0, 0, 0, 1);
        chk(int'(rx_rdata), 8'hB2, "R3 empty pop holds rdata");
        chk(int'(rx_count), 0, "R3 empty pop count stays 0");
        idle();
        chk(int'(irq), 0, "R8 no data no receive request");

        // Transmit empty select, byte mode
        rx_ie = 0; tx_ie = 1; txe_sel = 1; shift_busy = 1;
        idle();
        chk(int'(irq), 0, "R6 busy shifter holds request off");
        shift_busy = 0;
        idle();
        chk(int'(irq), 1, "R6 idle shifter raises request");
        txe_sel = 0; shift_busy = 1;
        idle();
        chk(int'(irq), 1, "R6 holding empty alone raises request");
        cyc(1, 8'h33, 0, 0, 0, 0);
        idle();
        chk(int'(irq), 0, "R6 byte in holding drops request");

        // Mode change flushes
        fifo_en = 1;
        idle();
        chk(int'(tx_count), 0, "R5 enable flushes transmit");

        // Fill to overflow and drain in order
        tx_ie = 0;
        for (int i = 0; i < DEPTH + 2; i++) cyc(1, DW'(i * 3 + 1), 0, 0, 0, 0);
        chk(int'(tx_count), DEPTH, "R1 full count");
        chk(int'(tx_ovf), 1, "R2 overflow set");
        cyc(1, 8'hEE, 1, 0, 0, 0);
        chk(int'(tx_count), DEPTH, "R1 push+pop when full");
        chk(int'(tx_rdata), 1, "R1 first byte out");
        for (int i = 1; i < DEPTH; i++) cyc(0, 0, 1, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0);
        chk(int'(tx_rdata), 8'hEE, "R1 last byte out in order");
        chk(int'(tx_ovf), 1, "R2 overflow sticky");

        // Trigger boundaries
        tx_ie = 0; rx_ie = 1; rx_trig = 5; dma_mode = 1;
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, DW'(i), 0);
        idle();
        chk(int'(irq), 0, "R8 count below trigger");
        cyc(0, 0, 0, 1, 8'h44, 0);
        idle();
        chk(int'(irq), 1, "R8 count equal to trigger");
        dma_mode = 0;
        idle();
        chk(int'(irq), 1, "R9 dma mode no effect");
        rx_ie = 0; tx_ie = 1; tx_trig = 3; txe_sel = 1; shift_busy = 1;
        for (int i = 0; i < 4; i++) cyc(1, DW'(i), 0, 0, 0, 0);
        idle();
        chk(int'(irq), 0, "R7 count above trigger");
        cyc(0, 0, 1, 0, 0, 0);
        idle();
        chk(int'(irq), 1, "R7 count equal to trigger");
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0, 0);
        idle();
        chk(int'(irq), 0, "R7 empty but shifter busy");
        txe_sel = 0;
        idle();
        chk(int'(irq), 1, "R7 empty queue raises request");
        fifo_en = 0;
        idle();
        chk(int'(rx_count), 0, "R5 disable flushes receive");

        // Random traffic
        for (int blk = 0; blk < 10; blk++) begin
            int pp;
            fifo_en = $urandom_range(0, 3) != 0;
            tx_trig = CW'($urandom_range(0, DEPTH));
            rx_trig = CW'($urandom_range(0, DEPTH));
            pp = (blk % 2 == 0) ? 75 : 35;
            for (int i = 0; i < 400; i++) begin
                if (i % 50 == 0) begin
                    tx_ie = $urandom_range(0, 1);
                    rx_ie = $urandom_range(0, 1);
                    txe_sel = $urandom_range(0, 1);
                    dma_mode = $urandom_range(0, 1);
                end
                shift_busy = $urandom_range(0, 1);
                cyc($urandom_range(0, 99) < pp, DW'($urandom), $urandom_range(0, 99) < 50,
                    $urandom_range(0, 99) < pp, DW'($urandom), $urandom_range(0, 99) < 50);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule